// File: doc/BRIEF.md
# Facility Data Link Receive Register

This block collects the data-link bits that a T1 framer pulls out of the line, one bit per strobe, and assembles them into bytes for a host processor. An optional zero destuffer sits in front of the byte assembler. When it is on, it deletes the zero that a transmitter inserts after a run of exactly five ones. A zero that ends a run of six or more ones is part of a flag or an abort pattern, so it is kept.

Each completed byte is latched into a receive holding register and raises a sticky buffer-full flag. The byte is also compared against two programmable match bytes, and a second sticky flag is raised when either one is equal. Each flag has a mask bit, and the active-low interrupt output is driven from the flags that are enabled. A read of the status register clears both flags.

The destuffer is a small state machine with three states. D_COUNT counts up to four consecutive ones. D_FIVE means exactly five ones have been seen. D_LONG means six or more ones have been seen. Every strobed zero returns the machine to D_COUNT and clears its count. A strobed one moves it from D_COUNT (after the fourth one) to D_FIVE, from D_FIVE to D_LONG, and keeps it in D_LONG.

Top module: `fdl_rx_reg`

Host register addresses:

| Address | Register | Bits | Access |
|---|---|---|---|
| 0 | control | bit 0 enables the destuffer | read/write |
| 1 | match A | 8-bit match byte | read/write |
| 2 | match B | 8-bit match byte | read/write |
| 3 | status | bit 0 buffer-full, bit 1 match | read clears |
| 4 | mask | bit 0 buffer-full, bit 1 match; a 1 enables the interrupt | read/write |
| 5 | receive byte | last completed byte | read only |

## Requirements
- R1: After reset, the control, match A, match B, mask, status and receive-byte registers all read 0, and irq_n is 1.
- R2: Eight kept bits form one byte. The first bit received lands in bit 7. The byte is readable at address 5, and status bit 0 is 1 two clock edges after the strobe of the eighth bit.
- R3: If a second byte completes before the host reads the first, the receive-byte register holds the second byte, and the first byte is lost.
- R4: Status bit 1 is set when a completed byte equals match A or match B, and not otherwise.
- R5: irq_n is 0 exactly while some status bit is 1 and its mask bit (address 4, same bit position) is 1.
- R6: A read of address 3 returns the flags and clears them on that clock edge. A flag that is set on the same edge stays set.
- R7: With control bit 0 cleared, every strobed bit is shifted in unchanged.
- R8: With control bit 0 set, a zero that directly follows exactly five consecutive ones is deleted.
- R9: A zero that follows six or more consecutive ones is kept.
- R10: Deleted bits do not advance the 8-bit fill count. The count of consecutive ones restarts at every zero.
- R11: Writes to the control, match A, match B and mask registers read back unchanged in their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid link bit |
| bit_in | input | 1 | Link bit value |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps all 256 byte values with the destuffer off and checks the latched byte, the full flag and the match flag on each one. A design with the bit order reversed, or with a broken comparator, fails across that sweep. With the destuffer on, it sends runs of zero to eight ones, each followed by a zero. A design that deletes the zero after six or more ones corrupts the runs of length six to eight. A design that lets deleted bits advance the fill count reports a full buffer one bit early. Further checks send two bytes without a read in between, which catches a design that keeps the older byte. Others toggle the masks while a flag is set, which catches an interrupt that ignores its enables or stays low after the clearing read.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NFLAG  = 2;
    localparam int FLG_FULL  = 0;
    localparam int FLG_MATCH = 1;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MATCH_A = 3'd1;
    localparam logic [ADDR_W-1:0] A_MATCH_B = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd4;
    localparam logic [ADDR_W-1:0] A_RXBYTE  = 3'd5;

    typedef enum logic [1:0] {
        D_COUNT = 2'd0,
        D_FIVE  = 2'd1,
        D_LONG  = 2'd2
    } dstate_e;
endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff
    import fdl_rx_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in_stb,
    input  logic in_bit,
    output logic out_stb,
    output logic out_bit
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    dstate_e        state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= D_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_stb) begin
            if (!in_bit) begin
                state_d = D_COUNT;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    D_COUNT: begin
                        if (cnt_q == LAST) begin
                            state_d = D_FIVE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    D_FIVE:  state_d = D_LONG;
                    D_LONG:  state_d = D_LONG;
                    default: state_d = D_COUNT;
                endcase
            end
        end
    end

    always_comb begin
        out_bit = in_bit;
        out_stb = in_stb && !(en && !in_bit && state_q == D_FIVE);
    end
endmodule

// File: rtl/fdl_shift.sv
module fdl_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_stb,
    input  logic         in_bit,
    output logic         done,
    output logic [W-1:0] byte_q
);
    localparam int FW = $clog2(W);
    localparam logic [FW-1:0] FULL_AT = FW'(W - 1);

    logic [W-1:0]  sr_q;
    logic [FW-1:0] fill_q;
    logic [W-1:0]  sr_next;

    assign sr_next = {sr_q[W-2:0], in_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
            byte_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_stb) begin
                sr_q <= sr_next;
                if (fill_q == FULL_AT) begin
                    fill_q <= '0;
                    byte_q <= sr_next;
                    done   <= 1'b1;
                end else begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fdl_rx_reg.sv
module fdl_rx_reg
    import fdl_rx_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic              kept_stb, kept_bit;
    logic              byte_done;
    logic [DATA_W-1:0] byte_val;
    logic              ctrl_q;
    logic [DATA_W-1:0] match_a_q, match_b_q;
    logic [NFLAG-1:0]  mask_q, flags_q, set_vec;
    logic              stat_rd;

    fdl_destuff #(.RUN_LEN(RUN_LEN)) u_destuff (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q),
        .in_stb(bit_stb), .in_bit(bit_in),
        .out_stb(kept_stb), .out_bit(kept_bit)
    );

    fdl_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .in_stb(kept_stb), .in_bit(kept_bit),
        .done(byte_done), .byte_q(byte_val)
    );

    assign stat_rd = reg_rd && (reg_addr == A_STATUS);

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_FULL]  = byte_done;
        set_vec[FLG_MATCH] = byte_done &&
                             (byte_val == match_a_q || byte_val == match_b_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= 1'b0;
            match_a_q <= '0;
            match_b_q <= '0;
            mask_q    <= '0;
            flags_q   <= '0;
        end else begin
            flags_q <= (stat_rd ? '0 : flags_q) | set_vec;
            if (reg_wr) begin
                if (reg_addr == A_CTRL)    ctrl_q    <= reg_wdata[0];
                if (reg_addr == A_MATCH_A) match_a_q <= reg_wdata;
                if (reg_addr == A_MATCH_B) match_b_q <= reg_wdata;
                if (reg_addr == A_MASK)    mask_q    <= reg_wdata[NFLAG-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == A_CTRL)    reg_rdata[0]         = ctrl_q;
            if (reg_addr == A_MATCH_A) reg_rdata            = match_a_q;
            if (reg_addr == A_MATCH_B) reg_rdata            = match_b_q;
            if (reg_addr == A_STATUS)  reg_rdata[NFLAG-1:0] = flags_q;
            if (reg_addr == A_MASK)    reg_rdata[NFLAG-1:0] = mask_q;
            if (reg_addr == A_RXBYTE)  reg_rdata            = byte_val;
        end
    end

    assign irq_n = ~|(flags_q & mask_q);
endmodule

// File: rtl/fdl_rx_chk.sv
module fdl_rx_chk
    import fdl_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              bit_in,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_n,
    input logic              kept_stb,
    input logic              byte_done,
    input logic [DATA_W-1:0] byte_val,
    input logic              ctrl_q,
    input logic [DATA_W-1:0] match_a_q,
    input logic [DATA_W-1:0] match_b_q,
    input logic [NFLAG-1:0]  flags_q
);
    p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> flags_q[FLG_FULL]);

    p_match_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && (byte_val == match_a_q || byte_val == match_b_q)
        |=> flags_q[FLG_MATCH]);

    p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(reg_rd || reg_wr));

    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == A_STATUS && !byte_done |=> flags_q == '0);

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done && !(reg_rd && reg_addr == A_STATUS) |=> $stable(flags_q));

    p_pass_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && !ctrl_q |-> kept_stb);

    p_drop_zero_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && !kept_stb |-> ctrl_q && !bit_in);
endmodule

bind fdl_rx_reg fdl_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq_n(irq_n),
    .kept_stb(kept_stb), .byte_done(byte_done), .byte_val(byte_val),
    .ctrl_q(ctrl_q), .match_a_q(match_a_q), .match_b_q(match_b_q),
    .flags_q(flags_q)
);

// File: tb/fdl_rx_reg_tb_top.sv
`timescale 1ns/1ps
module fdl_rx_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0, bit_in = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // bench model
    int       m_ones = 0, m_fill = 0;
    bit [7:0] m_sr = '0;
    bit       m_en = 0;
    bit [7:0] m_ma = '0, m_mb = '0;
    bit       auto_chk = 1;

    always #10 clk = ~clk;

    fdl_rx_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input bit b);
        bit del, complete;
        logic [7:0] v;
        @(negedge clk);
        bit_stb = 1'b1; bit_in = b;
        @(negedge clk);
        bit_stb = 1'b0;
        del = m_en && !b && (m_ones == 5);
        m_ones = b ? m_ones + 1 : 0;
        complete = 0;
        if (!del) begin
            m_sr = {m_sr[6:0], b};
            m_fill++;
            if (m_fill == 8) begin m_fill = 0; complete = 1; end
        end
        if (complete && auto_chk) begin
            rd(3'd5, v);
            chk(m_en ? "R8/R9 byte" : "R2/R7 byte", v, m_sr);
            rd(3'd3, v);
            chk("R2/R4 status", v, {6'd0, (m_sr == m_ma || m_sr == m_mb), 1'b1});
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send(v[i]);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 irq_n", irq_n, 1);

        // R11 readback
        wr(3'd1, 8'hA5); wr(3'd2, 8'h5A); wr(3'd4, 8'h03); wr(3'd0, 8'hFF);
        rd(3'd1, v); chk("R11 match A", v, 8'hA5);
        rd(3'd2, v); chk("R11 match B", v, 8'h5A);
        rd(3'd4, v); chk("R11 mask", v, 8'h03);
        rd(3'd0, v); chk("R11 ctrl", v, 8'h01);
        wr(3'd0, 8'h00); wr(3'd4, 8'h00);
        m_ma = 8'hA5; m_mb = 8'h5A; m_en = 0;

        // R2 R4 R7 all byte values, destuffer off
        for (int b = 0; b < 256; b++) send_byte(8'(b));

        // R3 overwrite
        auto_chk = 0;
        send_byte(8'h11); send_byte(8'h22);
        rd(3'd5, v); chk("R3 newest byte", v, 8'h22);
        rd(3'd3, v);

        // R5 mask behaviour
        wr(3'd4, 8'h01);
        send_byte(8'h33);
        @(negedge clk); chk("R5 irq low on full", irq_n, 0);
        rd(3'd3, v); chk("R6 status read value", v, 8'h01);
        #1 chk("R5 irq released after read", irq_n, 1);
        rd(3'd3, v); chk("R6 cleared", v, 8'h00);
        wr(3'd4, 8'h00);
        send_byte(8'h44);
        @(negedge clk); chk("R5 masked irq high", irq_n, 1);
        wr(3'd4, 8'h01);
        #1 chk("R5 unmask pending flag", irq_n, 0);
        rd(3'd3, v);
        wr(3'd4, 8'h02);
        send_byte(8'h44);
        @(negedge clk); chk("R5 no match irq high", irq_n, 1);
        rd(3'd3, v);
        send_byte(8'h5A);
        @(negedge clk); chk("R5 match irq low", irq_n, 0);
        rd(3'd3, v); chk("R4 match status", v, 8'h03);
        wr(3'd4, 8'h00);

        // R10 deleted bit does not advance fill
        wr(3'd0, 8'h01); m_en = 1;
        send(1); send(1); send(1); send(1); send(1); send(0); send(0); send(0);
        rd(3'd3, v); chk("R10 no full after deletion", v, 8'h00);
        send(1);
        rd(3'd5, v); chk("R10 byte after deletion", v, 8'hF9);
        rd(3'd3, v);
        m_ones = 1; m_sr = 8'hF9;
        auto_chk = 1;

        // R8 R9 runs of ones, destuffer on
        for (int k = 0; k <= 8; k++) begin
            for (int j = 0; j < k; j++) send(1);
            send(0);
            while (m_fill != 0) send(0);
        end
        for (int j = 0; j < 5; j++) begin
            send(1); send(0); send(1); send(1); send(1);
            send(1); send(1); send(0); send(1); send(1);
        end
        while (m_fill != 0) send(0);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule